// File: doc/BRIEF.md
# Multi-Port Control and Status Register Bank with Broadcast Writes

This block holds the control and status registers for a device with several identical ports, reached through a plain parallel host bus. That bus has an address, write data, read data, a write strobe and a read strobe. A single global control word sits at address 0. Above it, each port has its own address window. Each window holds three registers: a free control word, a latched status word and an interrupt enable mask. Event inputs set the latched status bits, and the bits stay set until the host clears them. Any set bit that its mask enables pulls the shared interrupt line active.

The global control word has four settings:
- A broadcast flag. While it is set, one host write lands in the same register of every port.
- A clear-policy selector. Latched bits are cleared either by writing ones to them or by reading them.
- The inactive drive of the interrupt line. When inactive, the line is either released or driven high.
- A data-path reset bit. It comes out of reset set, and it drives a reset output for the port data paths.

Top module: `mp_regbank`

Address layout: global word at 0x00. Port p (counting from 0) occupies 0x(p+1)0 to 0x(p+1)2. Within a port window, offset 0 is the control word, offset 1 is latched status and offset 2 is the mask. Global word fields: bit 0 is the data-path reset, bit 1 selects clear-on-read, bit 4 selects drive-high when idle, and bit 7 is broadcast. Event and status bit b of port p sits at position p*STAT_W+b of `evt_in`.

## Requirements
- R1: After a synchronous reset, the global word reads 0x0001, and every port's control, status and mask reads 0. `dp_reset_out` is 1 and `irq_oe` is 0.
- R2: Only global bits 0, 1, 4 and 7 are writable. All other global bits read as 0, whatever was written.
- R3: With global bit 7 clear, a write to a port register changes only the addressed port.
- R4: With global bit 7 set, a write to any port's control, status or mask register applies the same data to that register in every port.
- R5: A 1 on an event input sets the matching latched status bit on the next clock edge. The bit then stays 1 until it is cleared.
- R6: With global bit 1 clear, writing to a status register clears each bit written as 1 and leaves the bits written as 0. Reading does not clear.
- R7: With global bit 1 set, a status read returns the latched bits and clears them. Writes to a status register have no effect.
- R8: When an event arrives in the same cycle as a clear of the same bit, the bit remains set.
- R9: While any port has a latched status bit that is set and whose mask bit is 1, the interrupt is active: `irq_out`=0 and `irq_oe`=1.
- R10: While the interrupt is inactive, `irq_out`=1. `irq_oe` equals global bit 4: 0 releases the line, and 1 drives it high.
- R11: `dp_reset_out` always equals global bit 0.
- R12: Read data appears on `host_rdata` one clock after the read strobe and holds until the next read. Unmapped addresses read 0, and writes to them change nothing.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| host_addr | input | ADDR_W | Register address |
| host_wdata | input | DATA_W | Write data |
| host_wr | input | 1 | Write strobe, one cycle per write |
| host_rd | input | 1 | Read strobe, one cycle per read |
| host_rdata | output | DATA_W | Registered read data |
| evt_in | input | NUM_PORTS*STAT_W | Status event inputs, one bit per latched status bit |
| irq_out | output | 1 | Interrupt line value, low when active |
| irq_oe | output | 1 | Interrupt line output enable |
| dp_reset_out | output | 1 | Reset for the port data paths |

## Verification
The assertions take as given that `evt_in` is held at zero while reset is asserted. They also assume `host_wr` and `host_rd` are not both raised in the same cycle, so that the persistence check for latched bits can judge a cycle by its strobes alone. The bench drives one strobe per step, keeps events quiet across reset, and issues random reads only while broadcast mode is off. In broadcast mode, read values are not defined.

// File: rtl/mp_regbank_pkg.sv
`timescale 1ns/1ps
// Package: shared address offsets and global-word field positions for the
// multi-port register bank. Assumes a 4-bit register offset inside each block.
package mp_regbank_pkg;
    localparam int OFF_W      = 4;   // width of the in-window register offset
    localparam int OFF_CTRL   = 0;   // per-port control word
    localparam int OFF_STAT   = 1;   // per-port latched status
    localparam int OFF_MASK   = 2;   // per-port interrupt enable mask
    localparam int BIT_DPR    = 0;   // data-path reset
    localparam int BIT_COR    = 1;   // 1 = clear latched bits on read
    localparam int BIT_DRVHI  = 4;   // 1 = drive interrupt high when idle
    localparam int BIT_BCAST  = 7;   // 1 = broadcast port writes
endpackage

// File: rtl/mp_glob_ctrl.sv
`timescale 1ns/1ps
// Module: global control word. Holds the four writable settings and presents
// them as a read word with all other bits zero.
// Assumes: wr_en is a single-cycle strobe already qualified by address.
module mp_glob_ctrl
    import mp_regbank_pkg::*;
#(
    parameter int DATA_W = 16
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              wr_en,
    input  logic [DATA_W-1:0] wdata,
    output logic              bcast,
    output logic              clr_on_rd,
    output logic              drive_hi,
    output logic              dpr,
    output logic [DATA_W-1:0] rd_word
);

    // Capture the writable fields; data-path reset comes out of reset set.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            bcast     <= 1'b0;
            clr_on_rd <= 1'b0;
            drive_hi  <= 1'b0;
            dpr       <= 1'b1;
        end else if (wr_en) begin
            bcast     <= wdata[BIT_BCAST];
            clr_on_rd <= wdata[BIT_COR];
            drive_hi  <= wdata[BIT_DRVHI];
            dpr       <= wdata[BIT_DPR];
        end
    end

    // Assemble the read view with unused bits tied to zero.
    always_comb begin
        rd_word            = '0;
        rd_word[BIT_BCAST] = bcast;
        rd_word[BIT_COR]   = clr_on_rd;
        rd_word[BIT_DRVHI] = drive_hi;
        rd_word[BIT_DPR]   = dpr;
    end

endmodule

// File: rtl/mp_port_regs.sv
`timescale 1ns/1ps
// Module: one port's register set: control word, sticky latched status and
// interrupt mask, plus the port's interrupt request.
// Assumes: write/clear strobes are already decoded by the top; a clear and a
// new event on the same bit in one cycle leave the bit set.
module mp_port_regs #(
    parameter int DATA_W = 16,
    parameter int STAT_W = 8
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              wr_ctrl,
    input  logic              wr_mask,
    input  logic              wr_clr,
    input  logic              rd_clr,
    input  logic [DATA_W-1:0] wdata,
    input  logic [STAT_W-1:0] evt,
    output logic [DATA_W-1:0] ctrl_q,
    output logic [STAT_W-1:0] stat_q,
    output logic [STAT_W-1:0] mask_q,
    output logic              irq_req
);

    logic [STAT_W-1:0] clr_vec;

    // Form the bits to clear from a write-one or a clearing read.
    always_comb begin
        clr_vec = '0;
        if (wr_clr) clr_vec = clr_vec | wdata[STAT_W-1:0];
        if (rd_clr) clr_vec = clr_vec | stat_q;
    end

    // Control and mask registers load from the host.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            ctrl_q <= '0;
            mask_q <= '0;
        end else begin
            if (wr_ctrl) ctrl_q <= wdata;
            if (wr_mask) mask_q <= wdata[STAT_W-1:0];
        end
    end

    // Latched status: clear requested bits, then OR in new events (set wins).
    always_ff @(posedge clk) begin
        if (!rst_n) stat_q <= '0;
        else        stat_q <= (stat_q & ~clr_vec) | evt;
    end

    // Request an interrupt while any enabled latched bit is set.
    assign irq_req = |(stat_q & mask_q);

endmodule

// File: rtl/mp_irq_merge.sv
`timescale 1ns/1ps
// Module: combines per-port requests into one active-low interrupt line,
// modelled as a value plus an output enable for the idle drive choice.
// Assumes: req bits come straight from registered state.
module mp_irq_merge #(
    parameter int NUM_PORTS = 4
) (
    input  logic [NUM_PORTS-1:0] req,
    input  logic                 drive_hi,
    output logic                 irq_out,
    output logic                 irq_oe
);

    logic active;

    // Active when any port requests; idle enable follows the drive mode.
    always_comb begin
        active  = |req;
        irq_out = ~active;
        irq_oe  = active | drive_hi;
    end

endmodule

// File: rtl/mp_regbank.sv
`timescale 1ns/1ps
// Module: top of the multi-port register bank. Decodes the host address,
// fans writes out to one port or all ports, builds the registered read data
// and drives the interrupt and data-path reset outputs.
// Assumes: host_wr and host_rd are single-cycle strobes, not both high at
// once; read data is undefined while broadcast mode is on.
module mp_regbank
    import mp_regbank_pkg::*;
#(
    parameter int NUM_PORTS = 4,
    parameter int ADDR_W    = 8,
    parameter int DATA_W    = 16,
    parameter int STAT_W    = 8
) (
    input  logic                          clk,
    input  logic                          rst_n,
    input  logic [ADDR_W-1:0]             host_addr,
    input  logic [DATA_W-1:0]             host_wdata,
    input  logic                          host_wr,
    input  logic                          host_rd,
    output logic [DATA_W-1:0]             host_rdata,
    input  logic [NUM_PORTS*STAT_W-1:0]   evt_in,
    output logic                          irq_out,
    output logic                          irq_oe,
    output logic                          dp_reset_out
);

    localparam int BLK_W = ADDR_W - OFF_W;

    logic [BLK_W-1:0]            blk;
    logic [OFF_W-1:0]            off;
    logic                        glob_hit;
    logic                        port_hit;
    logic                        bcast_q;
    logic                        cor_q;
    logic                        drv_q;
    logic                        dpr_q;
    logic [DATA_W-1:0]           glob_word;
    logic [DATA_W-1:0]           ctrl_q [NUM_PORTS];
    logic [STAT_W-1:0]           stat_q [NUM_PORTS];
    logic [STAT_W-1:0]           mask_q [NUM_PORTS];
    logic [NUM_PORTS-1:0]        req;
    logic [NUM_PORTS*STAT_W-1:0] stat_flat;
    logic [DATA_W-1:0]           rd_mux;

    // Split the address into block number and in-window offset.
    assign blk = host_addr[ADDR_W-1:OFF_W];
    assign off = host_addr[OFF_W-1:0];

    // Recognise the global word and any mapped port register.
    always_comb begin
        glob_hit = (host_addr == '0);
        port_hit = (blk >= BLK_W'(1)) && (blk <= BLK_W'(NUM_PORTS)) &&
                   (off <= OFF_W'(OFF_MASK));
    end

    mp_glob_ctrl #(.DATA_W(DATA_W)) u_glob (
        .clk       (clk),
        .rst_n     (rst_n),
        .wr_en     (host_wr && glob_hit),
        .wdata     (host_wdata),
        .bcast     (bcast_q),
        .clr_on_rd (cor_q),
        .drive_hi  (drv_q),
        .dpr       (dpr_q),
        .rd_word   (glob_word)
    );

    for (genvar p = 0; p < NUM_PORTS; p++) begin : g_port
        logic own_hit;
        logic wr_sel;

        // This port is addressed directly, or reached by a broadcast write.
        always_comb begin
            own_hit = port_hit && (blk == BLK_W'(p + 1));
            wr_sel  = host_wr && (bcast_q ? port_hit : own_hit);
        end

        mp_port_regs #(.DATA_W(DATA_W), .STAT_W(STAT_W)) u_port (
            .clk     (clk),
            .rst_n   (rst_n),
            .wr_ctrl (wr_sel && (off == OFF_W'(OFF_CTRL))),
            .wr_mask (wr_sel && (off == OFF_W'(OFF_MASK))),
            .wr_clr  (wr_sel && (off == OFF_W'(OFF_STAT)) && !cor_q),
            .rd_clr  (host_rd && own_hit && (off == OFF_W'(OFF_STAT)) && cor_q),
            .wdata   (host_wdata),
            .evt     (evt_in[p*STAT_W +: STAT_W]),
            .ctrl_q  (ctrl_q[p]),
            .stat_q  (stat_q[p]),
            .mask_q  (mask_q[p]),
            .irq_req (req[p])
        );

        assign stat_flat[p*STAT_W +: STAT_W] = stat_q[p];
    end

    mp_irq_merge #(.NUM_PORTS(NUM_PORTS)) u_irq (
        .req      (req),
        .drive_hi (drv_q),
        .irq_out  (irq_out),
        .irq_oe   (irq_oe)
    );

    // Select the addressed register; unmapped addresses give zero.
    always_comb begin
        rd_mux = '0;
        if (glob_hit) rd_mux = glob_word;
        for (int p = 0; p < NUM_PORTS; p++) begin
            if (port_hit && (blk == BLK_W'(p + 1))) begin
                if (off == OFF_W'(OFF_CTRL)) rd_mux = ctrl_q[p];
                if (off == OFF_W'(OFF_STAT)) rd_mux = DATA_W'(stat_q[p]);
                if (off == OFF_W'(OFF_MASK)) rd_mux = DATA_W'(mask_q[p]);
            end
        end
    end

    // Register read data on the read strobe and hold it otherwise.
    always_ff @(posedge clk) begin
        if (!rst_n)       host_rdata <= '0;
        else if (host_rd) host_rdata <= rd_mux;
    end

    assign dp_reset_out = dpr_q;

endmodule

// File: rtl/mp_regbank_chk.sv
`timescale 1ns/1ps
// Module: assertion checker for mp_regbank, attached by bind.
// Assumes: evt_in is zero during reset and host strobes are never both high.
module mp_regbank_chk
    import mp_regbank_pkg::*;
#(
    parameter int NUM_PORTS = 4,
    parameter int ADDR_W    = 8,
    parameter int DATA_W    = 16,
    parameter int STAT_W    = 8
) (
    input logic                        clk,
    input logic                        rst_n,
    input logic [ADDR_W-1:0]           host_addr,
    input logic                        host_wr,
    input logic                        host_rd,
    input logic [DATA_W-1:0]           host_rdata,
    input logic [NUM_PORTS*STAT_W-1:0] evt_in,
    input logic [NUM_PORTS*STAT_W-1:0] stat_flat,
    input logic                        irq_out,
    input logic                        irq_oe,
    input logic                        dp_reset_out,
    input logic                        cor,
    input logic                        drive_hi
);

    localparam logic [DATA_W-1:0] KEEP =
        DATA_W'((1 << BIT_DPR) | (1 << BIT_COR) | (1 << BIT_DRVHI) | (1 << BIT_BCAST));

    AST_DPR_AFTER_RESET: assert property (@(posedge clk) disable iff (!rst_n)
        ($past(rst_n) == 1'b0) |-> dp_reset_out); // R1

    AST_GLOB_RSV_ZERO: assert property (@(posedge clk) disable iff (!rst_n)
        ($past(rst_n) && $past(host_rd) && ($past(host_addr) == '0))
        |-> ((host_rdata & ~KEEP) == '0)); // R2

    AST_STAT_STICKY: assert property (@(posedge clk) disable iff (!rst_n)
        ($past(rst_n) && !$past(host_wr) && !($past(host_rd) && $past(cor)))
        |-> ((stat_flat & $past(stat_flat)) == $past(stat_flat))); // R5

    AST_EVT_SET_WINS: assert property (@(posedge clk) disable iff (!rst_n)
        $past(rst_n) |-> ((stat_flat & $past(evt_in)) == $past(evt_in))); // R8

    AST_IRQ_ACTIVE_DRIVEN: assert property (@(posedge clk) disable iff (!rst_n)
        !irq_out |-> irq_oe); // R9

    AST_IRQ_IDLE_HIGH: assert property (@(posedge clk) disable iff (!rst_n)
        !irq_oe |-> irq_out); // R10

    AST_IRQ_IDLE_MODE: assert property (@(posedge clk) disable iff (!rst_n)
        (irq_oe && irq_out) |-> drive_hi); // R10

endmodule

bind mp_regbank mp_regbank_chk #(
    .NUM_PORTS(NUM_PORTS), .ADDR_W(ADDR_W), .DATA_W(DATA_W), .STAT_W(STAT_W)
) u_chk (
    .clk          (clk),
    .rst_n        (rst_n),
    .host_addr    (host_addr),
    .host_wr      (host_wr),
    .host_rd      (host_rd),
    .host_rdata   (host_rdata),
    .evt_in       (evt_in),
    .stat_flat    (stat_flat),
    .irq_out      (irq_out),
    .irq_oe       (irq_oe),
    .dp_reset_out (dp_reset_out),
    .cor          (cor_q),
    .drive_hi     (drv_q)
);

// File: tb/mp_regbank_test.sv
`timescale 1ns/1ps
// Bench: directed corner cases, then seeded random traffic, all checked
// against a behavioural model kept in the bench.
module mp_regbank_test;
    localparam int NP = 4;
    localparam int SW = 8;

    logic            clk = 1'b0;
    logic            rst_n = 1'b0;
    logic [7:0]      host_addr = '0;
    logic [15:0]     host_wdata = '0;
    logic            host_wr = 1'b0;
    logic            host_rd = 1'b0;
    logic [15:0]     host_rdata;
    logic [NP*SW-1:0] evt_in = '0;
    logic            irq_out, irq_oe, dp_reset_out;

    int n_chk = 0;
    int n_bad = 0;

    logic [15:0] m_glob;
    logic [15:0] m_ctrl [NP];
    logic [7:0]  m_stat [NP];
    logic [7:0]  m_mask [NP];

    always #5 clk = ~clk;

    mp_regbank uut (
        .clk(clk), .rst_n(rst_n), .host_addr(host_addr), .host_wdata(host_wdata),
        .host_wr(host_wr), .host_rd(host_rd), .host_rdata(host_rdata),
        .evt_in(evt_in), .irq_out(irq_out), .irq_oe(irq_oe),
        .dp_reset_out(dp_reset_out)
    );

    task automatic chk(input string tag, input logic [31:0] act, input logic [31:0] exp);
        n_chk++;
        if (act !== exp) begin
            n_bad++;
            $display("FAIL %s actual=%h expected=%h", tag, act, exp);
        end
    endtask

    function automatic logic [15:0] model_read(input logic [7:0] a);
        int b = int'(a[7:4]);
        int o = int'(a[3:0]);
        if (a == 8'h00) return m_glob;
        if (b >= 1 && b <= NP) begin
            if (o == 0) return m_ctrl[b-1];
            if (o == 1) return {8'h00, m_stat[b-1]};
            if (o == 2) return {8'h00, m_mask[b-1]};
        end
        return 16'h0000;
    endfunction

    task automatic model_reset();
        m_glob = 16'h0001;
        for (int p = 0; p < NP; p++) begin
            m_ctrl[p] = '0; m_stat[p] = '0; m_mask[p] = '0;
        end
    endtask

    task automatic model_update(input logic wr, input logic rd, input logic [7:0] a,
                                input logic [15:0] d, input logic [NP*SW-1:0] ev);
        int b = int'(a[7:4]);
        int o = int'(a[3:0]);
        logic [7:0] clr [NP];
        for (int p = 0; p < NP; p++) clr[p] = '0;
        if (wr && a == 8'h00) m_glob = d & 16'h0093;
        else if (wr && b >= 1 && b <= NP && o <= 2) begin
            for (int p = 0; p < NP; p++) begin
                if (m_glob[7] || p == b-1) begin
                    if (o == 0) m_ctrl[p] = d;
                    if (o == 2) m_mask[p] = d[7:0];
                    if (o == 1 && !m_glob[1]) clr[p] = d[7:0];
                end
            end
        end
        if (rd && b >= 1 && b <= NP && o == 1 && m_glob[1]) clr[b-1] = m_stat[b-1];
        for (int p = 0; p < NP; p++) m_stat[p] = (m_stat[p] & ~clr[p]) | ev[p*SW +: SW];
    endtask

    // One bus cycle: drive at a falling edge, check at the next falling edge.
    task automatic step(input logic wr, input logic rd, input logic [7:0] a,
                        input logic [15:0] d, input logic [NP*SW-1:0] ev,
                        input bit chk_rd, input string tag);
        logic [15:0] exp_rd;
        logic act;
        exp_rd = model_read(a);
        host_wr = wr; host_rd = rd; host_addr = a; host_wdata = d; evt_in = ev;
        @(negedge clk);
        host_wr = 1'b0; host_rd = 1'b0; evt_in = '0;
        model_update(wr, rd, a, d, ev);
        if (rd && chk_rd) chk(tag, 32'(host_rdata), 32'(exp_rd));
        act = 1'b0;
        for (int p = 0; p < NP; p++) if ((m_stat[p] & m_mask[p]) != 0) act = 1'b1;
        chk("R9 irq_out", 32'(irq_out), 32'(!act));
        chk("R10 irq_oe", 32'(irq_oe), 32'(act | m_glob[4]));
        chk("R11 dp_reset_out", 32'(dp_reset_out), 32'(m_glob[0]));
    endtask

    task automatic wr_reg(input logic [7:0] a, input logic [15:0] d);
        step(1'b1, 1'b0, a, d, '0, 1'b0, "wr");
    endtask

    task automatic rd_reg(input logic [7:0] a, input string tag);
        step(1'b0, 1'b1, a, 16'h0, '0, 1'b1, tag);
    endtask

    task automatic finish_run();
        $display("  %0d/%0d checks passed", n_chk - n_bad, n_chk);
        $finish;
    endtask

    initial begin
        #2_000_000;
        n_chk++; n_bad++;
        $display("FAIL watchdog expired");
        finish_run();
    end

    initial begin
        logic [15:0] snap;
        void'($urandom(32'd20240611));
        model_reset();
        repeat (3) @(negedge clk);
        rst_n = 1'b1;

        // R1: reset state
        chk("R1 dp_reset_out", 32'(dp_reset_out), 32'd1);
        chk("R1 irq_oe", 32'(irq_oe), 32'd0);
        rd_reg(8'h00, "R1 global word");
        for (int p = 0; p < NP; p++) begin
            rd_reg(8'((p+1)*16 + 0), "R1 ctrl");
            rd_reg(8'((p+1)*16 + 1), "R1 status");
            rd_reg(8'((p+1)*16 + 2), "R1 mask");
        end

        // R2: reserved bits of the global word read zero
        wr_reg(8'h00, 16'hFFFF);
        rd_reg(8'h00, "R2 global writable bits");
        wr_reg(8'h00, 16'h0000);
        rd_reg(8'h00, "R11 data-path reset cleared");

        // R3: single-port write leaves others alone
        wr_reg(8'h20, 16'h1234);
        rd_reg(8'h20, "R3 addressed port");
        rd_reg(8'h10, "R3 other port");
        rd_reg(8'h30, "R3 other port");

        // R4: broadcast write reaches every port
        wr_reg(8'h00, 16'h0080);
        wr_reg(8'h30, 16'hBEEF);
        wr_reg(8'h12, 16'h00F0);
        wr_reg(8'h00, 16'h0000);
        for (int p = 0; p < NP; p++) begin
            rd_reg(8'((p+1)*16 + 0), "R4 broadcast ctrl");
            rd_reg(8'((p+1)*16 + 2), "R4 broadcast mask");
        end
        wr_reg(8'h00, 16'h0080);
        for (int p = 0; p < NP; p++) wr_reg(8'((p+1)*16 + 2), 16'h0000);
        wr_reg(8'h00, 16'h0000);

        // R5/R6: event sets; write-one clears only written bits; read keeps
        step(1'b0, 1'b0, 8'h00, 16'h0, 32'h0000_0C00, 1'b0, "ev");
        rd_reg(8'h21, "R5 latched after event");
        rd_reg(8'h21, "R6 read does not clear");
        wr_reg(8'h21, 16'h0004);
        rd_reg(8'h21, "R6 write-one clears only that bit");

        // R8: event and clear in the same cycle
        step(1'b1, 1'b0, 8'h21, 16'h0008, 32'h0000_0800, 1'b0, "R8");
        rd_reg(8'h21, "R8 set wins over clear");

        // R7: clear-on-read mode
        wr_reg(8'h00, 16'h0002);
        step(1'b0, 1'b0, 8'h00, 16'h0, 32'h0005_0000, 1'b0, "ev");
        wr_reg(8'h31, 16'h00FF);
        rd_reg(8'h31, "R7 write ignored, read returns bits");
        rd_reg(8'h31, "R7 read cleared bits");
        step(1'b0, 1'b1, 8'h31, 16'h0, 32'h0002_0000, 1'b1, "R8 read-clear with event");
        rd_reg(8'h31, "R8 set wins over read clear");
        rd_reg(8'h21, "R7 clear read of port 1");

        // R9/R10: interrupt drive modes
        wr_reg(8'h00, 16'h0010);
        chk("R10 idle drive high oe", 32'(irq_oe), 32'd1);
        chk("R10 idle drive high out", 32'(irq_out), 32'd1);
        wr_reg(8'h42, 16'h0004);
        step(1'b0, 1'b0, 8'h00, 16'h0, 32'h0400_0000, 1'b0, "ev");
        chk("R9 active low", 32'(irq_out), 32'd0);
        wr_reg(8'h41, 16'h0004);
        wr_reg(8'h00, 16'h0000);
        chk("R10 idle released", 32'(irq_oe), 32'd0);

        // R12: unmapped addresses and read-data hold
        wr_reg(8'h5F, 16'hAAAA);
        wr_reg(8'h13, 16'h5555);
        rd_reg(8'h13, "R12 unmapped offset reads zero");
        rd_reg(8'h50, "R12 unmapped block reads zero");
        rd_reg(8'h20, "R12 read data");
        snap = host_rdata;
        step(1'b0, 1'b0, 8'h10, 16'h0, '0, 1'b0, "idle");
        chk("R12 read data holds", 32'(host_rdata), 32'(snap));

        // Seeded random traffic (R3 R4 R5 R6 R7 R8)
        for (int i = 0; i < 1500; i++) begin
            int op = int'($urandom % 10);
            int p  = int'($urandom % NP);
            int o  = int'($urandom % 3);
            logic [7:0] a = 8'((p+1)*16 + o);
            logic [15:0] d = 16'($urandom);
            logic [NP*SW-1:0] ev = ($urandom % 3 == 0) ? ($urandom & $urandom & $urandom) : '0;
            if ($urandom % 12 == 0) a = 8'h63;
            if (op == 0) begin
                d = d & 16'h0073;
                if ($urandom % 5 == 0) d[7] = 1'b1;
                d[0] = 1'b0;
                step(1'b1, 1'b0, 8'h00, d, ev, 1'b0, "rand global");
            end else if (op < 5) begin
                step(1'b1, 1'b0, a, d, ev, 1'b0, "rand write");
            end else if (op < 9) begin
                step(1'b0, 1'b1, a, 16'h0, ev, !m_glob[7], "R5 R6 R7 random read");
            end else begin
                step(1'b0, 1'b0, a, 16'h0, ev, 1'b0, "rand idle");
            end
        end
        wr_reg(8'h00, 16'h0000);
        for (int p = 0; p < NP; p++) rd_reg(8'((p+1)*16 + 1), "R5 final status");

        finish_run();
    end
endmodule